// File: doc/BRIEF.md
# Sub-Converter Skew Correction Controller

This block closes the background timing-skew loop of a four-way interleaved converter. An upstream accumulator gathers one statistic per sampling interval: interval k runs from sub-converter k to sub-converter k+1, wrapping from 3 back to 0. When a window ends, the accumulator raises a one-cycle strobe with all four sums valid. The controller works out how far each sum lies from the mean of the four. If every deviation sits inside a programmable dead band, it declares the converter aligned. Otherwise it looks for a pair of neighbouring intervals whose deviations have opposite signs, and moves the sub-converter they share by one delay cell.

Each sub-converter has a delay line of unit cells, and the controller drives a count of how many cells are switched on. Every code starts at half scale, so each sampling instant can move earlier or later. After every window the controller pulses a clear to the accumulator, so the next window starts from zero. The loop runs without end in the background, and a converged flag shows whether the last window fell entirely inside the dead band.

Top module: `skewCalCtrl`

## Requirements
- R1: During and after reset, until the first decision, every delay code is CELLS/2 (16 by default), `converged` is 0 and `clearAcc` is 0.
- R2: The mean is the sum of the four window sums shifted right by 2, so any remainder is dropped. Each deviation is the sum of its own interval minus that mean, compared in signed arithmetic one bit wider than a sum.
- R3: When no deviation is strictly greater than `thresh` in magnitude, no code changes and `converged` becomes 1. A deviation equal to `thresh` counts as inside the dead band.
- R4: Pairs (k, k+1 mod 4) are scanned for k = 0, 1, 2, 3. At the first pair where deviation k > `thresh` and deviation k+1 < -`thresh`, the code of sub-converter k+1 drops by one.
- R5: At the first pair where deviation k < -`thresh` and deviation k+1 > `thresh`, the code of sub-converter k+1 rises by one.
- R6: Each window changes at most one code, by exactly one step. When several pairs qualify, only the pair with the lowest k acts.
- R7: Codes saturate: they never go below 0 or above CELLS (32), and a step at a limit leaves the code unchanged.
- R8: A `windowDone` pulse sampled at one clock edge causes, at the second edge after it, a one-cycle `clearAcc` pulse, together with the code and `converged` update for that window. Windows on back-to-back cycles are each handled in turn.
- R9: `converged` returns to 0 after any window with a deviation outside the dead band, even when no pair qualifies and no code moves.
- R10: `sumsIn` carries sum k, unsigned, in bits [16k+15:16k]. `delayCode` carries the code of sub-converter k in bits [6k+5:6k], as the number of enabled cells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| windowDone | input | 1 | One-cycle strobe: the window sums are valid |
| sumsIn | input | 4*SUM_W | Four unsigned interval sums, sum k in slice k |
| thresh | input | SUM_W | Dead-band half width, unsigned |
| delayCode | output | 4*CODE_W | Enabled-cell count per sub-converter, code k in slice k |
| clearAcc | output | 1 | One-cycle command to clear the accumulator |
| converged | output | 1 | The last window had all deviations in the dead band |

## Verification
The hardest states to reach are the rails of a delay code and the pair that wraps from interval 3 to interval 0. A code at either rail takes sixteen consecutive windows that each push the same sub-converter in the same direction. The stimulus therefore repeats one skewed pattern in a long run until the code must sit at 0, and then another until a second code must sit at 32. Patterns where several pairs qualify at once, windows one remainder above a multiple of four, a deviation exactly equal to the threshold, and two window strobes on adjacent cycles show up the ordering, truncation and pipelining corners.

// File: rtl/skewCalPkg.sv
package skewCalPkg;
  localparam int NUM_CH = 4;
  localparam int MEAN_SHIFT = $clog2(NUM_CH);

  typedef struct packed {
    logic latch;   // capture deviation flags from the presented sums
    logic apply;   // commit the selected code step
  } calStrobe_t;
endpackage

// File: rtl/skewCodeCell.sv
module skewCodeCell #(
  parameter int CELLS  = 32,
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              incEn,
  input  logic              decEn,
  output logic [CODE_W-1:0] code
);
  localparam logic [CODE_W-1:0] CODE_MAX  = CODE_W'(CELLS);
  localparam logic [CODE_W-1:0] CODE_MID  = CODE_W'(CELLS / 2);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      code <= CODE_MID;
    end else if (incEn && (code < CODE_MAX)) begin
      code <= code + 1'b1;
    end else if (decEn && (code != '0)) begin
      code <= code - 1'b1;
    end
  end
endmodule

// File: rtl/skewDatapath.sv
module skewDatapath
  import skewCalPkg::*;
#(
  parameter int SUM_W  = 16,
  parameter int CELLS  = 32,
  parameter int CODE_W = 6
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  calStrobe_t               strobe,
  input  logic [NUM_CH*SUM_W-1:0]  sumsIn,
  input  logic [SUM_W-1:0]         thresh,
  input  logic [NUM_CH-1:0]        stepUp,
  input  logic [NUM_CH-1:0]        stepDown,
  output logic [NUM_CH-1:0]        overHi,
  output logic [NUM_CH-1:0]        underLo,
  output logic [NUM_CH*CODE_W-1:0] codeOut
);
  localparam int TOT_W = SUM_W + MEAN_SHIFT;
  localparam int DEV_W = SUM_W + 1;

  logic [TOT_W-1:0]        total;
  logic [SUM_W-1:0]        meanVal;
  logic signed [DEV_W-1:0] thPos;
  logic signed [DEV_W-1:0] thNeg;
  logic signed [DEV_W-1:0] devVal [NUM_CH];
  logic [NUM_CH-1:0]       hiNow;
  logic [NUM_CH-1:0]       loNow;

  always_comb begin
    total = '0;
    for (int k = 0; k < NUM_CH; k++) begin
      total = total + {{MEAN_SHIFT{1'b0}}, sumsIn[k*SUM_W +: SUM_W]};
    end
  end

  assign meanVal = total[TOT_W-1:MEAN_SHIFT];
  assign thPos   = $signed({1'b0, thresh});
  assign thNeg   = -thPos;

  always_comb begin
    for (int k = 0; k < NUM_CH; k++) begin
      devVal[k] = $signed({1'b0, sumsIn[k*SUM_W +: SUM_W]}) - $signed({1'b0, meanVal});
      hiNow[k]  = devVal[k] > thPos;
      loNow[k]  = devVal[k] < thNeg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      overHi  <= '0;
      underLo <= '0;
    end else if (strobe.latch) begin
      overHi  <= hiNow;
      underLo <= loNow;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : gCell
    skewCodeCell #(
      .CELLS (CELLS),
      .CODE_W(CODE_W)
    ) uCell (
      .clk  (clk),
      .rstN (rstN),
      .incEn(strobe.apply & stepUp[g]),
      .decEn(strobe.apply & stepDown[g]),
      .code (codeOut[g*CODE_W +: CODE_W])
    );
  end
endmodule

// File: rtl/skewControl.sv
module skewControl
  import skewCalPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              windowDone,
  input  logic [NUM_CH-1:0] overHi,
  input  logic [NUM_CH-1:0] underLo,
  output calStrobe_t        strobe,
  output logic [NUM_CH-1:0] stepUp,
  output logic [NUM_CH-1:0] stepDown,
  output logic              clearAcc,
  output logic              converged
);
  logic evalPending;
  logic pairFound;
  logic anyOut;

  assign strobe.latch = windowDone;
  assign strobe.apply = evalPending;
  assign anyOut       = |(overHi | underLo);

  // scan neighbouring intervals, lowest index first; only one step per window
  always_comb begin
    stepUp    = '0;
    stepDown  = '0;
    pairFound = 1'b0;
    for (int k = 0; k < NUM_CH; k++) begin
      if (!pairFound && overHi[k] && underLo[(k + 1) % NUM_CH]) begin
        stepDown[(k + 1) % NUM_CH] = 1'b1;
        pairFound = 1'b1;
      end else if (!pairFound && underLo[k] && overHi[(k + 1) % NUM_CH]) begin
        stepUp[(k + 1) % NUM_CH] = 1'b1;
        pairFound = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evalPending <= 1'b0;
      clearAcc    <= 1'b0;
      converged   <= 1'b0;
    end else begin
      evalPending <= windowDone;
      clearAcc    <= evalPending;
      if (evalPending) begin
        converged <= !anyOut;
      end
    end
  end
endmodule

// File: rtl/skewCalCtrl.sv
module skewCalCtrl
  import skewCalPkg::*;
#(
  parameter int SUM_W = 16,
  parameter int CELLS = 32,
  localparam int CODE_W = $clog2(CELLS + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     windowDone,
  input  logic [NUM_CH*SUM_W-1:0]  sumsIn,
  input  logic [SUM_W-1:0]         thresh,
  output logic [NUM_CH*CODE_W-1:0] delayCode,
  output logic                     clearAcc,
  output logic                     converged
);
  calStrobe_t        strobe;
  logic [NUM_CH-1:0] overHi;
  logic [NUM_CH-1:0] underLo;
  logic [NUM_CH-1:0] stepUp;
  logic [NUM_CH-1:0] stepDown;

  skewControl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .windowDone(windowDone),
    .overHi    (overHi),
    .underLo   (underLo),
    .strobe    (strobe),
    .stepUp    (stepUp),
    .stepDown  (stepDown),
    .clearAcc  (clearAcc),
    .converged (converged)
  );

  skewDatapath #(
    .SUM_W (SUM_W),
    .CELLS (CELLS),
    .CODE_W(CODE_W)
  ) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .sumsIn  (sumsIn),
    .thresh  (thresh),
    .stepUp  (stepUp),
    .stepDown(stepDown),
    .overHi  (overHi),
    .underLo (underLo),
    .codeOut (delayCode)
  );
endmodule

// File: rtl/skewCalChecker.sv
module skewCalChecker
  import skewCalPkg::*;
#(
  parameter int CELLS  = 32,
  parameter int CODE_W = 6
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     windowDone,
  input logic [NUM_CH*CODE_W-1:0] delayCode,
  input logic                     clearAcc,
  input logic                     converged
);
  logic [NUM_CH*CODE_W-1:0] prevCode;
  logic [NUM_CH-1:0]        codeMoved;

  always_ff @(posedge clk) prevCode <= delayCode;

  always_comb begin
    for (int k = 0; k < NUM_CH; k++) begin
      codeMoved[k] = delayCode[k*CODE_W +: CODE_W] != prevCode[k*CODE_W +: CODE_W];
    end
  end

  // R6: never more than one code moves in a cycle
  assert_single_move_R6: assert property (@(posedge clk) disable iff (!rstN)
    $countones(codeMoved) <= 1);

  // R8: codes move only together with the clear pulse
  assert_move_with_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (delayCode != $past(delayCode)) |-> clearAcc);

  // R8: a clear pulse always traces back to a window strobe two edges earlier
  assert_clear_origin_R8: assert property (@(posedge clk) disable iff (!rstN)
    clearAcc |-> $past(windowDone, 2));

  // R3: the converged flag changes only at a decision
  assert_conv_timing_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(converged) |-> clearAcc);

  for (genvar g = 0; g < NUM_CH; g++) begin : gChan
    // R7: each code stays within the delay line
    assert_code_range_R7: assert property (@(posedge clk) disable iff (!rstN)
      delayCode[g*CODE_W +: CODE_W] <= CODE_W'(CELLS));

    // R6: a code moves by one step at most
    assert_unit_step_R6: assert property (@(posedge clk) disable iff (!rstN)
      (delayCode[g*CODE_W +: CODE_W] == $past(delayCode[g*CODE_W +: CODE_W])) ||
      (delayCode[g*CODE_W +: CODE_W] == $past(delayCode[g*CODE_W +: CODE_W]) + 1'b1) ||
      (delayCode[g*CODE_W +: CODE_W] == $past(delayCode[g*CODE_W +: CODE_W]) - 1'b1));
  end
endmodule

bind skewCalCtrl skewCalChecker #(
  .CELLS (CELLS),
  .CODE_W(CODE_W)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .windowDone(windowDone),
  .delayCode (delayCode),
  .clearAcc  (clearAcc),
  .converged (converged)
);

// File: tb/sim_skewCalCtrl.sv
`timescale 1ns/1ps
module sim_skewCalCtrl;
  localparam int SW = 16;
  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          windowDone = 1'b0;
  logic [4*SW-1:0] sumsIn = '0;
  logic [SW-1:0] thresh = '0;
  logic [4*CW-1:0] delayCode;
  logic          clearAcc;
  logic          converged;

  int checks = 0;
  int errors = 0;
  bit running = 1'b0;

  always #10 clk = ~clk;

  skewCalCtrl #(.SUM_W(SW), .CELLS(32)) u0 (
    .clk(clk), .rstN(rstN), .windowDone(windowDone), .sumsIn(sumsIn),
    .thresh(thresh), .delayCode(delayCode), .clearAcc(clearAcc), .converged(converged)
  );

  // behavioural reference: one pending window, integer arithmetic
  int mCode[4];
  int mConv, mClear, mPend;
  int mHi[4], mLo[4];

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (mCode[i]) begin mCode[i] = 16; mHi[i] = 0; mLo[i] = 0; end
      mConv = 0; mClear = 0; mPend = 0;
    end else begin
      mClear = mPend;
      if (mPend != 0) begin
        int done;
        int outAny;
        done = 0; outAny = 0;
        for (int k = 0; k < 4; k++) begin
          int n;
          n = (k + 1) % 4;
          if (mHi[k] != 0 || mLo[k] != 0) outAny = 1;
          if (done == 0 && mHi[k] != 0 && mLo[n] != 0) begin
            if (mCode[n] > 0) mCode[n] = mCode[n] - 1;
            done = 1;
          end else if (done == 0 && mLo[k] != 0 && mHi[n] != 0) begin
            if (mCode[n] < 32) mCode[n] = mCode[n] + 1;
            done = 1;
          end
        end
        mConv = (outAny == 0) ? 1 : 0;
      end
      mPend = windowDone ? 1 : 0;
      if (windowDone) begin
        int tot;
        int avg;
        tot = 0;
        for (int k = 0; k < 4; k++) tot = tot + int'(sumsIn[k*SW +: SW]);
        avg = tot / 4;
        for (int k = 0; k < 4; k++) begin
          int dv;
          dv = int'(sumsIn[k*SW +: SW]) - avg;
          mHi[k] = (dv > int'(thresh)) ? 1 : 0;
          mLo[k] = (dv < -int'(thresh)) ? 1 : 0;
        end
      end
    end
  end

  // every-cycle comparison against the reference
  always @(negedge clk) begin
    if (running) begin
      for (int k = 0; k < 4; k++) begin
        checks++;
        if (int'(delayCode[k*CW +: CW]) != mCode[k]) begin
          errors++;
          $display("FAIL R4/R5/R7 model code%0d actual %0d expected %0d", k, delayCode[k*CW +: CW], mCode[k]);
        end
      end
      checks++;
      if (int'(clearAcc) != mClear) begin
        errors++;
        $display("FAIL R8 model clearAcc actual %0d expected %0d", clearAcc, mClear);
      end
      checks++;
      if (int'(converged) != mConv) begin
        errors++;
        $display("FAIL R3/R9 model converged actual %0d expected %0d", converged, mConv);
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic expectState(input string tag, input int c0, input int c1,
                             input int c2, input int c3, input int cv);
    check({tag, " code0"}, int'(delayCode[5:0]), c0);
    check({tag, " code1"}, int'(delayCode[11:6]), c1);
    check({tag, " code2"}, int'(delayCode[17:12]), c2);
    check({tag, " code3"}, int'(delayCode[23:18]), c3);
    check({tag, " converged"}, int'(converged), cv);
  endtask

  // strobe one window; returns at the negedge where its result is visible
  task automatic window(input int s0, input int s1, input int s2, input int s3, input int th);
    @(negedge clk);
    sumsIn = {SW'(s3), SW'(s2), SW'(s1), SW'(s0)};
    thresh = SW'(th);
    windowDone = 1'b1;
    @(negedge clk);
    windowDone = 1'b0;
    check("R8 no clear one edge after strobe", int'(clearAcc), 0);
    @(negedge clk);
    check("R8 clear two edges after strobe", int'(clearAcc), 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset values, R10 field layout
    expectState("R1 R10 reset", 16, 16, 16, 16, 0);
    check("R1 reset clearAcc", int'(clearAcc), 0);
    rstN = 1'b1;
    running = 1'b1;
    repeat (2) @(negedge clk);
    expectState("R1 after reset", 16, 16, 16, 16, 0);

    window(100, 100, 100, 100, 2);
    expectState("R3 balanced window", 16, 16, 16, 16, 1);
    @(negedge clk);
    check("R8 clear lasts one cycle", int'(clearAcc), 0);

    window(120, 80, 100, 100, 5);
    expectState("R4 lower code1", 16, 15, 16, 16, 0);
    window(80, 120, 100, 100, 5);
    expectState("R5 raise code1", 16, 16, 16, 16, 0);
    window(80, 100, 100, 120, 5);
    expectState("R4 wrap pair lowers code0", 15, 16, 16, 16, 0);
    window(130, 70, 130, 70, 5);
    expectState("R6 lowest pair only", 15, 15, 16, 16, 0);
    window(100, 100, 100, 100, 2);
    expectState("R3 hold when in band", 15, 15, 16, 16, 1);
    window(130, 90, 90, 90, 15);
    expectState("R9 out of band without pair", 15, 15, 16, 16, 0);
    window(3, 0, 0, 0, 2);
    expectState("R2 truncated mean out of band", 15, 15, 16, 16, 0);
    window(3, 0, 0, 0, 3);
    expectState("R2 R3 deviation equal to threshold", 15, 15, 16, 16, 1);

    // R8 back-to-back strobes: two decisions, two steps
    @(negedge clk);
    sumsIn = {SW'(100), SW'(100), SW'(80), SW'(120)};
    thresh = SW'(5);
    windowDone = 1'b1;
    @(negedge clk);
    @(negedge clk);
    windowDone = 1'b0;
    check("R8 first of paired clears", int'(clearAcc), 1);
    @(negedge clk);
    check("R8 second of paired clears", int'(clearAcc), 1);
    expectState("R8 back-to-back windows", 15, 13, 16, 16, 0);
    repeat (2) @(negedge clk);

    // R7 saturation at both rails
    for (int i = 0; i < 20; i++) window(100, 120, 80, 100, 5);
    expectState("R7 floor at zero", 15, 13, 0, 16, 0);
    for (int i = 0; i < 20; i++) window(100, 100, 80, 120, 5);
    expectState("R7 ceiling at full scale", 15, 13, 0, 32, 0);
    window(100, 100, 100, 100, 0);
    expectState("R3 R7 settled hold", 15, 13, 0, 32, 1);

    repeat (3) @(negedge clk);
    running = 1'b0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule